// File: doc/BRIEF.md
# Direct-Mapped Flash Page Controller

This controller joins a host port that reads and writes single pages to a raw flash port. The raw flash port accepts three commands: page read, page program and block erase. No mapping table is kept, so host page N is always flash page N. A host read becomes one flash page read.

A host write cannot program a page in place, because flash only programs erased pages. The controller therefore runs a full read-modify-write of the erase block that holds the target page. It reads every page of that block into a register buffer, erases the block, and then programs every page back. The target page takes the new host data and every other page takes its buffered old contents.

Two free-running 32-bit counters record host page writes and flash page programs. The ratio of the two shows the write amplification, which for this controller is always the number of pages per erase block. The host port uses a valid/ready handshake. `req_ready` stays low for the whole flash sequence, so a request made during that time is held off and taken later, never lost.

Top module: `dm_ftl_ctrl`

## Requirements
- R1: Out of reset, `req_ready` is 1, `fl_cmd_valid` is 0 and both counters read 0.
- R2: A host read (`req_write`=0) issues exactly one flash command, op code 0 (read), at address `req_page`. `resp_valid` then pulses with `resp_rdata` equal to the data the flash returned.
- R3: A host write first issues a read (op 0) for each page of the containing block, in ascending page order from the block's first page.
- R4: After those reads, exactly one erase (op 2) is issued, addressed to the first page of the block. No program is issued before this erase.
- R5: After the erase, every page of the block is programmed (op 1) in ascending order. The target page receives `req_wdata` and every other page receives the value read from it earlier.
- R6: Each host write adds 1 to `host_wr_count` and adds exactly PAGES_PER_BLK to `prog_count`.
- R7: At most one flash command is outstanding. The next command is issued only after a `fl_done` pulse answers the previous one.
- R8: `req_ready` is low from acceptance until the response pulse. A request held during that time is accepted afterwards and served normally.
- R9: Host reads leave both counters unchanged, and the counters are readable at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Controller idle, request accepted this cycle if valid |
| req_write | input | 1 | 1 = page write, 0 = page read |
| req_page | input | AW | Logical (= physical) page index |
| req_wdata | input | DATA_W | Write data |
| resp_valid | output | 1 | One-cycle completion pulse |
| resp_rdata | output | DATA_W | Read data, valid with the pulse of a read |
| fl_cmd_valid | output | 1 | One-cycle flash command strobe |
| fl_cmd_op | output | 2 | 0 read, 1 program, 2 erase |
| fl_addr | output | AW | Page address (block's first page for erase) |
| fl_wdata | output | DATA_W | Program data |
| fl_done | input | 1 | Flash command finished pulse |
| fl_rdata | input | DATA_W | Read data, valid with `fl_done` |
| host_wr_count | output | 32 | Host page writes accepted |
| prog_count | output | 32 | Flash page programs completed |

## Verification
Two things can happen in the same cycle: the completion of a write sequence and the arrival of the next host request. The bench holds a read request valid during an entire write. It checks that `req_ready` stays low throughout, that the read is taken only after the write's response pulse, and that it then produces exactly one flash read with the correct merged data. A simulated flash rejects any program to a page that has not been erased, and it varies its busy time from command to command. Every page is written in turn and then read back against an arithmetic reference.

// File: rtl/dm_ftl_ctrl.sv
module dm_ftl_ctrl #(
  parameter int PAGES_PER_BLK = 4,
  parameter int NUM_BLOCKS    = 8,
  parameter int DATA_W        = 16,
  localparam int OFF_W = $clog2(PAGES_PER_BLK),
  localparam int BLK_W = $clog2(NUM_BLOCKS),
  localparam int AW    = OFF_W + BLK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [AW-1:0]     req_page,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              resp_valid,
  output logic [DATA_W-1:0] resp_rdata,
  output logic              fl_cmd_valid,
  output logic [1:0]        fl_cmd_op,
  output logic [AW-1:0]     fl_addr,
  output logic [DATA_W-1:0] fl_wdata,
  input  logic              fl_done,
  input  logic [DATA_W-1:0] fl_rdata,
  output logic [31:0]       host_wr_count,
  output logic [31:0]       prog_count
);
  localparam logic [1:0] OP_READ = 2'd0, OP_PROG = 2'd1, OP_ERASE = 2'd2;

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT} st_t;
  typedef enum logic [1:0] {P_READ, P_BUF, P_ERASE, P_PROG} ph_t;

  st_t               st;
  ph_t               ph;
  logic [OFF_W-1:0]  idx;
  logic [AW-1:0]     page_q;
  logic [DATA_W-1:0] data_q;
  logic [DATA_W-1:0] blk_buf [PAGES_PER_BLK];

  wire last = (idx == OFF_W'(PAGES_PER_BLK - 1));

  assign req_ready    = (st == S_IDLE);
  assign fl_cmd_valid = (st == S_ISSUE);
  assign fl_cmd_op    = (ph == P_PROG) ? OP_PROG : (ph == P_ERASE) ? OP_ERASE : OP_READ;
  assign fl_addr      = (ph == P_READ) ? page_q : {page_q[AW-1:OFF_W], idx};
  assign fl_wdata     = (idx == page_q[OFF_W-1:0]) ? data_q : blk_buf[idx];

  always_ff @(posedge clk)
    if (st == S_WAIT && fl_done && ph == P_BUF)
      blk_buf[idx] <= fl_rdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st            <= S_IDLE;
      ph            <= P_READ;
      idx           <= '0;
      page_q        <= '0;
      data_q        <= '0;
      resp_valid    <= 1'b0;
      resp_rdata    <= '0;
      host_wr_count <= '0;
      prog_count    <= '0;
    end else begin
      resp_valid <= 1'b0;
      case (st)
        S_IDLE:
          if (req_valid) begin
            page_q <= req_page;
            data_q <= req_wdata;
            idx    <= '0;
            ph     <= req_write ? P_BUF : P_READ;
            st     <= S_ISSUE;
            if (req_write) host_wr_count <= host_wr_count + 32'd1;
          end
        S_ISSUE: st <= S_WAIT;
        default:
          if (fl_done) begin
            st <= S_ISSUE;
            case (ph)
              P_READ: begin
                resp_rdata <= fl_rdata;
                resp_valid <= 1'b1;
                st         <= S_IDLE;
              end
              P_BUF:
                if (last) begin
                  ph  <= P_ERASE;
                  idx <= '0;
                end else idx <= idx + 1'b1;
              P_ERASE: ph <= P_PROG;
              default: begin
                prog_count <= prog_count + 32'd1;
                if (last) begin
                  resp_valid <= 1'b1;
                  st         <= S_IDLE;
                end else idx <= idx + 1'b1;
              end
            endcase
          end
      endcase
    end
  end
endmodule

// File: rtl/dm_ftl_ctrl_chk.sv
module dm_ftl_ctrl_chk #(
  parameter int AW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          req_write,
  input logic [AW-1:0] req_page,
  input logic          fl_cmd_valid,
  input logic [1:0]    fl_cmd_op,
  input logic [AW-1:0] fl_addr,
  input logic          fl_done,
  input logic [31:0]   host_wr_count,
  input logic [31:0]   prog_count
);
  logic          outstanding, erased_seen, acc_wr;
  logic [AW-1:0] acc_page;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outstanding <= 1'b0;
      erased_seen <= 1'b0;
      acc_wr      <= 1'b0;
      acc_page    <= '0;
    end else begin
      if (fl_cmd_valid) outstanding <= 1'b1;
      else if (fl_done) outstanding <= 1'b0;
      if (req_valid && req_ready) begin
        acc_wr      <= req_write;
        acc_page    <= req_page;
        erased_seen <= 1'b0;
      end else if (fl_cmd_valid && fl_cmd_op == 2'd2) erased_seen <= 1'b1;
    end
  end

  AST_READ_SAME_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_cmd_valid && !acc_wr) |-> (fl_cmd_op == 2'd0 && fl_addr == acc_page)); // R2
  AST_ERASE_BEFORE_PROG: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_cmd_valid && fl_cmd_op == 2'd1) |-> erased_seen); // R4
  AST_PROG_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_count == $past(prog_count)) || (prog_count == $past(prog_count) + 32'd1)); // R6
  AST_WRCNT_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr_count != $past(host_wr_count)) |-> $past(req_valid && req_ready && req_write)); // R6
  AST_SINGLE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    fl_cmd_valid |-> !outstanding); // R7
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_cmd_valid || outstanding) |-> !req_ready); // R8
endmodule

bind dm_ftl_ctrl dm_ftl_ctrl_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .req_page(req_page), .fl_cmd_valid(fl_cmd_valid),
  .fl_cmd_op(fl_cmd_op), .fl_addr(fl_addr), .fl_done(fl_done),
  .host_wr_count(host_wr_count), .prog_count(prog_count)
);

// File: tb/test_dm_ftl_ctrl.sv
module test_dm_ftl_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int PPB = 4;
  localparam int NB  = 4;
  localparam int DW  = 16;
  localparam int NP  = PPB * NB;
  localparam int AW  = $clog2(NP);

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_page = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, resp_valid, fl_cmd_valid, fl_done;
  logic [DW-1:0] resp_rdata, fl_wdata, fl_rdata;
  logic [1:0] fl_cmd_op;
  logic [AW-1:0] fl_addr;
  logic [31:0] host_wr_count, prog_count;

  always #(CLK_PERIOD/2) clk = ~clk;

  dm_ftl_ctrl #(.PAGES_PER_BLK(PPB), .NUM_BLOCKS(NB), .DATA_W(DW)) i_dm_ftl_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_page(req_page), .req_wdata(req_wdata),
    .resp_valid(resp_valid), .resp_rdata(resp_rdata), .fl_cmd_valid(fl_cmd_valid),
    .fl_cmd_op(fl_cmd_op), .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_done(fl_done),
    .fl_rdata(fl_rdata), .host_wr_count(host_wr_count), .prog_count(prog_count));

  // flash model with varying busy time and a command log
  logic [DW-1:0] mem [NP];
  logic          erased [NP];
  logic [1:0]    log_op   [1024];
  logic [AW-1:0] log_addr [1024];
  logic [DW-1:0] log_data [1024];
  int cmd_total = 0, busy_cnt = 0, prog_bad = 0, overlap = 0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fl_done  <= 1'b0;
      fl_rdata <= '0;
      busy_cnt <= 0;
      for (int i = 0; i < NP; i++) begin
        mem[i]    <= DW'(i * 37 + 5);
        erased[i] <= 1'b0;
      end
    end else begin
      fl_done <= 1'b0;
      if (busy_cnt > 0) begin
        busy_cnt <= busy_cnt - 1;
        if (busy_cnt == 1) fl_done <= 1'b1;
        if (fl_cmd_valid) overlap <= overlap + 1;
      end else if (fl_cmd_valid) begin
        log_op[cmd_total % 1024]   <= fl_cmd_op;
        log_addr[cmd_total % 1024] <= fl_addr;
        log_data[cmd_total % 1024] <= fl_wdata;
        cmd_total <= cmd_total + 1;
        busy_cnt  <= 1 + (cmd_total % 3);
        case (fl_cmd_op)
          2'd0: fl_rdata <= mem[fl_addr];
          2'd1: begin
            if (!erased[fl_addr]) prog_bad <= prog_bad + 1;
            mem[fl_addr]    <= fl_wdata;
            erased[fl_addr] <= 1'b0;
          end
          default:
            for (int i = 0; i < PPB; i++) begin
              mem[(int'(fl_addr) & ~(PPB-1)) + i]    <= '1;
              erased[(int'(fl_addr) & ~(PPB-1)) + i] <= 1'b1;
            end
        endcase
      end
    end
  end

  int checks = 0, errors = 0;
  logic [DW-1:0] ref_mem [NP];

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic host_op(input bit wr, input int pg, input logic [DW-1:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_page = AW'(pg); req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (!resp_valid) @(negedge clk);
  endtask

  task automatic check_write_log(input int start, input int pg, input logic [DW-1:0] d);
    int base;
    bit seq_ok, ord_ok, prg_ok;
    base = pg & ~(PPB-1);
    seq_ok = 1; ord_ok = 1; prg_ok = 1;
    chk(cmd_total - start == 2*PPB + 1, "R7 command count per write", cmd_total - start, 2*PPB + 1);
    for (int i = 0; i < PPB; i++)
      if (log_op[start+i] != 2'd0 || int'(log_addr[start+i]) != base + i) seq_ok = 0;
    chk(seq_ok, "R3 block read order", pg, base);
    ord_ok = (log_op[start+PPB] == 2'd2) && (int'(log_addr[start+PPB]) == base);
    chk(ord_ok, "R4 single erase at block start", int'(log_addr[start+PPB]), base);
    for (int i = 0; i < PPB; i++) begin
      int k = start + PPB + 1 + i;
      if (log_op[k] != 2'd1 || int'(log_addr[k]) != base + i ||
          log_data[k] != ((base + i == pg) ? d : ref_mem[base+i])) prg_ok = 0;
    end
    chk(prg_ok, "R5 merged reprogram", pg, base);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int nw, start, rd_start;
    logic [DW-1:0] d;
    for (int i = 0; i < NP; i++) ref_mem[i] = DW'(i * 37 + 5);
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
    chk(fl_cmd_valid == 1'b0, "R1 no command in reset", fl_cmd_valid, 0);
    chk(host_wr_count == 0 && prog_count == 0, "R1 counters zero", host_wr_count + prog_count, 0);
    rst_n = 1'b1;

    // R2: read every page before any write
    for (int p = 0; p < NP; p++) begin
      start = cmd_total;
      host_op(1'b0, p, '0);
      chk(resp_rdata == ref_mem[p], "R2 read data", resp_rdata, ref_mem[p]);
      chk(cmd_total - start == 1 && log_op[start] == 2'd0 && int'(log_addr[start]) == p,
          "R2 single read at same page", int'(log_addr[start]), p);
    end
    chk(host_wr_count == 0 && prog_count == 0, "R9 reads leave counters", prog_count, 0);

    // sweep: write every page in scrambled order
    nw = 0;
    for (int j = 0; j < NP; j++) begin
      int p = (j * 5 + 3) % NP;
      d = DW'(16'hA000 ^ (p * 291 + j));
      start = cmd_total;
      host_op(1'b1, p, d);
      nw++;
      check_write_log(start, p, d);
      ref_mem[p] = d;
      chk(host_wr_count == nw, "R6 host write count", host_wr_count, nw);
      chk(prog_count == nw * PPB, "R6 program count", prog_count, nw * PPB);
    end

    for (int p = 0; p < NP; p++) begin
      host_op(1'b0, p, '0);
      chk(resp_rdata == ref_mem[p], "R5 readback after writes", resp_rdata, ref_mem[p]);
    end

    // R8: read held valid during a write
    begin
      bit ready_leak;
      int wr_pg, rd_pg;
      wr_pg = 6; rd_pg = 7; d = 16'h5A5A;
      ready_leak = 0;
      start = cmd_total;
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1; req_page = AW'(wr_pg); req_wdata = d;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_write = 1'b0; req_page = AW'(rd_pg); req_wdata = '0;
      while (!resp_valid) begin
        if (req_ready) ready_leak = 1;
        @(negedge clk);
      end
      nw++;
      chk(!ready_leak, "R8 ready low while busy", ready_leak, 0);
      check_write_log(start, wr_pg, d);
      ref_mem[wr_pg] = d;
      rd_start = cmd_total;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      while (!resp_valid) @(negedge clk);
      chk(resp_rdata == ref_mem[rd_pg], "R8 held read served", resp_rdata, ref_mem[rd_pg]);
      chk(cmd_total - rd_start == 1 && int'(log_addr[rd_start]) == rd_pg,
          "R8 held read single command", cmd_total - rd_start, 1);
      chk(host_wr_count == nw && prog_count == nw * PPB, "R9 counters after mixed", prog_count, nw * PPB);
    end

    chk(prog_bad == 0, "R4 no program on unerased page", prog_bad, 0);
    chk(overlap == 0, "R7 no command while flash busy", overlap, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule